// File: doc/BRIEF.md
# Gate Driver Master Enable and Fault-Clear Control

This block owns the master enable of a three-phase gate driver and the command that clears its latched faults. Both arrive through one 16-bit control word. The word is written over a simple port that carries an address, data and a strobe. The enable sits in bit 15 and the clear command in bit 0. A 3-bit lock field in bits 3:1 guards eleven configuration bits in bits 14:4.

The block watches four status inputs:
- the combined shutdown-class fault flag;
- the hardware driver-off pin;
- the power-up ready indication;
- the all-channel shutdown option.

From these it decides whether a write may turn the driver on, and when hardware must turn it off. After ready first rises, the block waits a set number of cycles before it accepts an enable. This wait covers the settling time the analog stages need after power-up.

A clear command gives a single-cycle pulse to the fault latches. If a clear and an enable arrive in one write while a fault is latched, only the clear takes effect.

Top module: `drv_enable_ctrl`

## Requirements
- R1: After synchronous reset, `drv_en_o` is 0, `clr_pulse_o` is 0 and `rd_word_o` is 16'h0006: enable 0, configuration 0, lock field 011b, bit 0 read as 0.
- R2: A write to `CTRL_ADDR` with bit 15 = 1 sets the enable from the next cycle, but only when setting is permitted. A write with bit 15 = 0 clears the enable.
- R3: While `drv_off` is high, the enable is forced to 0 from the next cycle, and writes cannot set it.
- R4: When `fault_latched` and `all_ch_cfg` are both 1, the enable is forced to 0. When `fault_latched` is 1 and `all_ch_cfg` is 0, an enable that is already on stays on. While `fault_latched` is 1, no write can set the enable.
- R5: Writes that try to set the enable have no effect until `pwr_ready` has been high at least once since reset.
- R6: An enable write is rejected until `SETTLE_CYC` clock edges have passed with the ready state seen, counted from the first edge at which `pwr_ready` is high.
- R7: A write with both bit 15 and bit 0 set while `fault_latched` is 1 only clears. The enable stays 0.
- R8: A write with bit 0 = 1 makes `clr_pulse_o` high for exactly the next cycle. Bit 0 always reads back as 0.
- R9: Lock field behaviour:
  - Writing 011b to bits 3:1 locks the field and writing 110b unlocks it. Any other value leaves the field unchanged.
  - While the field is 011b, writes leave bits 14:4 unchanged.
  - Enable and clear bits are accepted whether the field is locked or not.
- R10: Writes to any other address change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 16 | Write data: enable bit 15, configuration 14:4, lock 3:1, clear 0 |
| fault_latched | input | 1 | Any shutdown-class fault flag latched |
| all_ch_cfg | input | 1 | All-channel shutdown option |
| drv_off | input | 1 | Hardware driver-off pin |
| pwr_ready | input | 1 | Power-up ready indication |
| drv_en_o | output | 1 | Effective master enable |
| clr_pulse_o | output | 1 | One-cycle clear pulse to the fault latches |
| rd_word_o | output | 16 | Readback of the control word |

## Verification
On every cycle, the assertions check these behaviours:
- the forced turn-off caused by the driver-off pin and by an all-channel fault;
- that every rising edge of the enable traces back to a permitted enable write;
- that each clear pulse follows a clear write;
- that a locked field freezes the configuration bits.

Some behaviours can only be shown by the bench's scenarios:
- the power-up rejection and the exact settle window;
- the clear-over-enable priority while a fault is latched;
- that a fault with the all-channel option off leaves a running enable alone;
- the lock command decoding, including the ignored codes;
- the readback word values.

// File: rtl/drv_enable_pkg.sv
package drv_enable_pkg;
    localparam int WORD_W = 16;
    localparam int CFG_W  = 11;
    localparam int LOCK_W = 3;

    typedef struct packed {
        logic              enable;
        logic [CFG_W-1:0]  cfg;
        logic [LOCK_W-1:0] lock;
        logic              clr;
    } ctrl_word_t;

    typedef enum logic [LOCK_W-1:0] {
        LOCK_SHUT = 3'b011,
        LOCK_OPEN = 3'b110
    } lock_cmd_e;

    localparam logic [LOCK_W-1:0] LOCK_RESET = LOCK_SHUT;

    function automatic logic is_lock_cmd(input logic [LOCK_W-1:0] v);
        return (v == LOCK_SHUT) || (v == LOCK_OPEN);
    endfunction
endpackage

// File: rtl/drv_settle_timer.sv
module drv_settle_timer #(
    parameter int SETTLE_CYC = 1250
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_ready,
    output logic settled
);
    localparam int CNT_W = (SETTLE_CYC < 1) ? 1 : $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SETTLE_CYC);

    logic             ready_seen;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_seen <= 1'b0;
            cnt        <= '0;
        end else begin
            if (pwr_ready)
                ready_seen <= 1'b1;
            if ((pwr_ready || ready_seen) && cnt != LIMIT)
                cnt <= CNT_W'(cnt + 1'b1);
        end
    end

    assign settled = ready_seen && (cnt == LIMIT);
endmodule

// File: rtl/drv_lock_cfg.sv
module drv_lock_cfg
    import drv_enable_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  ctrl_word_t        wr_word,
    output logic [CFG_W-1:0]  cfg,
    output logic [LOCK_W-1:0] lock
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lock <= LOCK_RESET;
            cfg  <= '0;
        end else if (wr_hit) begin
            if (is_lock_cmd(wr_word.lock))
                lock <= wr_word.lock;
            if (lock == LOCK_OPEN)
                cfg <= wr_word.cfg;
        end
    end
endmodule

// File: rtl/drv_enable_core.sv
module drv_enable_core (
    input  logic clk,
    input  logic rst,
    input  logic wr_hit,
    input  logic wr_en_bit,
    input  logic wr_clr_bit,
    input  logic fault_latched,
    input  logic all_ch_cfg,
    input  logic drv_off,
    input  logic settled,
    output logic enable,
    output logic clr_pulse
);
    logic force_off;
    logic clr_wins;
    logic set_ok;

    assign force_off = drv_off || (fault_latched && all_ch_cfg);
    assign clr_wins  = wr_clr_bit && fault_latched;
    assign set_ok    = settled && !drv_off && !fault_latched && !clr_wins;

    always_ff @(posedge clk) begin
        if (rst) begin
            enable    <= 1'b0;
            clr_pulse <= 1'b0;
        end else begin
            clr_pulse <= wr_hit && wr_clr_bit;
            if (force_off)
                enable <= 1'b0;
            else if (wr_hit) begin
                if (!wr_en_bit)
                    enable <= 1'b0;
                else if (set_ok)
                    enable <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/drv_enable_ctrl.sv
module drv_enable_ctrl
    import drv_enable_pkg::*;
#(
    parameter int              ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h1B,
    parameter int              SETTLE_CYC = 1250
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              fault_latched,
    input  logic              all_ch_cfg,
    input  logic              drv_off,
    input  logic              pwr_ready,
    output logic              drv_en_o,
    output logic              clr_pulse_o,
    output logic [WORD_W-1:0] rd_word_o
);
    ctrl_word_t        wr_word;
    ctrl_word_t        rd_word;
    logic              wr_hit;
    logic              settled;
    logic [CFG_W-1:0]  cfg;
    logic [LOCK_W-1:0] lock;

    assign wr_word = ctrl_word_t'(wr_data);
    assign wr_hit  = wr_en && (wr_addr == CTRL_ADDR);

    drv_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk       (clk),
        .rst       (rst),
        .pwr_ready (pwr_ready),
        .settled   (settled)
    );

    drv_lock_cfg u_lock (
        .clk     (clk),
        .rst     (rst),
        .wr_hit  (wr_hit),
        .wr_word (wr_word),
        .cfg     (cfg),
        .lock    (lock)
    );

    drv_enable_core u_core (
        .clk           (clk),
        .rst           (rst),
        .wr_hit        (wr_hit),
        .wr_en_bit     (wr_word.enable),
        .wr_clr_bit    (wr_word.clr),
        .fault_latched (fault_latched),
        .all_ch_cfg    (all_ch_cfg),
        .drv_off       (drv_off),
        .settled       (settled),
        .enable        (drv_en_o),
        .clr_pulse     (clr_pulse_o)
    );

    always_comb begin
        rd_word.enable = drv_en_o;
        rd_word.cfg    = cfg;
        rd_word.lock   = lock;
        rd_word.clr    = 1'b0;
    end
    assign rd_word_o = rd_word;
endmodule

// File: rtl/drv_enable_chk.sv
module drv_enable_chk #(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h1B
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [15:0]       wr_data,
    input logic              fault_latched,
    input logic              all_ch_cfg,
    input logic              drv_off,
    input logic              drv_en_o,
    input logic              clr_pulse_o,
    input logic [15:0]       rd_word_o
);
    AST_DRVOFF_FORCES_OFF: assert property (@(posedge clk) disable iff (rst)
        drv_off |=> !drv_en_o); // R3

    AST_ALLCH_FAULT_OFF: assert property (@(posedge clk) disable iff (rst)
        (fault_latched && all_ch_cfg) |=> !drv_en_o); // R4

    AST_RISE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(drv_en_o) |-> $past(wr_en && wr_addr == CTRL_ADDR && wr_data[15]
                                  && !drv_off && !fault_latched)); // R2

    AST_CLR_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        clr_pulse_o |-> $past(wr_en && wr_addr == CTRL_ADDR && wr_data[0])); // R8

    AST_LOCK_FREEZES_CFG: assert property (@(posedge clk) disable iff (rst)
        (rd_word_o[3:1] == 3'b011) |=> $stable(rd_word_o[14:4])); // R9
endmodule

bind drv_enable_ctrl drv_enable_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .fault_latched (fault_latched),
    .all_ch_cfg    (all_ch_cfg),
    .drv_off       (drv_off),
    .drv_en_o      (drv_en_o),
    .clr_pulse_o   (clr_pulse_o),
    .rd_word_o     (rd_word_o)
);

// File: tb/sim_drv_enable_ctrl.sv
`timescale 1ns/1ps
module sim_drv_enable_ctrl;
    localparam int          SETTLE = 20;
    localparam logic [7:0]  CTRL   = 8'h1B;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        fault_latched = 1'b0;
    logic        all_ch_cfg = 1'b1;
    logic        drv_off = 1'b0;
    logic        pwr_ready = 1'b0;
    logic        drv_en_o;
    logic        clr_pulse_o;
    logic [15:0] rd_word_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    drv_enable_ctrl #(.ADDR_W(8), .CTRL_ADDR(CTRL), .SETTLE_CYC(SETTLE)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .fault_latched(fault_latched), .all_ch_cfg(all_ch_cfg), .drv_off(drv_off),
        .pwr_ready(pwr_ready), .drv_en_o(drv_en_o), .clr_pulse_o(clr_pulse_o),
        .rd_word_o(rd_word_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 enable", 16'(drv_en_o), 16'h0);
        chk("R1 pulse", 16'(clr_pulse_o), 16'h0);
        chk("R1 readback", rd_word_o, 16'h0006);
    endtask

    task automatic t_power();
        wr(CTRL, 16'h8000);
        chk("R5 set before ready", 16'(drv_en_o), 16'h0);
        pwr_ready = 1'b1;
        wr(CTRL, 16'h8000);
        chk("R6 set inside settle window", 16'(drv_en_o), 16'h0);
        repeat (SETTLE + 5) @(negedge clk);
        wr(CTRL, 16'h8000);
        chk("R6 set after settle", 16'(drv_en_o), 16'h1);
        wr(CTRL, 16'h0000);
        chk("R2 clear by write", 16'(drv_en_o), 16'h0);
        wr(CTRL, 16'h8000);
        chk("R2 set by write", 16'(drv_en_o), 16'h1);
    endtask

    task automatic t_drvoff();
        drv_off = 1'b1;
        @(negedge clk);
        chk("R3 forced off", 16'(drv_en_o), 16'h0);
        wr(CTRL, 16'h8000);
        chk("R3 set blocked", 16'(drv_en_o), 16'h0);
        drv_off = 1'b0;
        @(negedge clk);
        chk("R3 stays off after release", 16'(drv_en_o), 16'h0);
        wr(CTRL, 16'h8000);
        chk("R3 set after release", 16'(drv_en_o), 16'h1);
    endtask

    task automatic t_fault();
        all_ch_cfg = 1'b0; fault_latched = 1'b1;
        @(negedge clk);
        chk("R4 no clear without all-channel", 16'(drv_en_o), 16'h1);
        all_ch_cfg = 1'b1;
        @(negedge clk);
        chk("R4 cleared by all-channel fault", 16'(drv_en_o), 16'h0);
        all_ch_cfg = 1'b0;
        wr(CTRL, 16'h8000);
        chk("R4 set blocked by fault", 16'(drv_en_o), 16'h0);
        wr(CTRL, 16'h8001);
        chk("R7 clear wins over enable", 16'(drv_en_o), 16'h0);
        chk("R8 pulse after clear write", 16'(clr_pulse_o), 16'h1);
        fault_latched = 1'b0;
        @(negedge clk);
        chk("R8 pulse lasts one cycle", 16'(clr_pulse_o), 16'h0);
        chk("R7 enable still off", 16'(drv_en_o), 16'h0);
        all_ch_cfg = 1'b1;
    endtask

    task automatic t_clr_nofault();
        wr(CTRL, 16'h8001);
        chk("R8 enable with clear and no fault", 16'(drv_en_o), 16'h1);
        chk("R8 pulse", 16'(clr_pulse_o), 16'h1);
        chk("R8 clear reads 0", 16'(rd_word_o[0]), 16'h0);
        @(negedge clk);
        chk("R8 pulse ends", 16'(clr_pulse_o), 16'h0);
    endtask

    task automatic t_other_addr();
        wr(8'h1C, 16'h0000);
        chk("R10 enable untouched", 16'(drv_en_o), 16'h1);
        chk("R10 readback untouched", rd_word_o, 16'h8006);
        chk("R10 no pulse", 16'(clr_pulse_o), 16'h0);
    endtask

    task automatic t_lock();
        wr(CTRL, 16'h8FF6);
        chk("R9 locked cfg blocked", rd_word_o, 16'h8006);
        wr(CTRL, 16'h800C);
        chk("R9 unlock", rd_word_o, 16'h800C);
        wr(CTRL, 16'h8FFC);
        chk("R9 cfg written when open", rd_word_o, 16'h8FFC);
        wr(CTRL, 16'h855A);
        chk("R9 undefined lock code ignored", rd_word_o, 16'h855C);
        wr(CTRL, 16'h8556);
        chk("R9 relock", rd_word_o, 16'h8556);
        wr(CTRL, 16'h0006);
        chk("R9 enable clear accepted while locked", rd_word_o, 16'h0556);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_power();
        t_drvoff();
        t_fault();
        t_clr_nofault();
        t_other_addr();
        t_lock();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule